// File: doc/BRIEF.md
# Addressed Multi-Queue FIFO

This block holds thirty-two independent first-in first-out queues in one shared storage array. The write side and the read side run on separate clocks. Each side picks its active queue by presenting an 8-bit selection word together with a one-cycle select strobe. The upper three bits of that word must equal the block's strapped identity, and the lower five bits name the queue. Words are written into the active write queue while the write enable is high. Reads come from the active read queue in first-word-fall-through fashion: the head word sits on the output register before anyone asks for it.

A write-queue change goes through a short pipeline, so writes issued right around the strobe still land in the queue that was active before. For the queue currently selected for reading, the block drives an active-low almost-empty flag. Its threshold is a single level shared by all queues. The flag follows the write side only through a two-stage Gray-code synchronizer, so it lags a write by a few read cycles.

Top module: `mqueue_fifo`

## Requirements
- R1: A select strobe takes effect only when selection bits [7:5] equal the parameter DEV_ID (default 5). Bits [4:0] then name the queue. A strobe carrying any other identity leaves the current selection unchanged.
- R2: Writes issued in the write cycle of a select strobe and in the cycle after it go to the previously selected queue. Writes from the second cycle after the strobe onward go to the newly selected queue.
- R3: Each queue holds at most 16 words. A write to a full queue is ignored, and the 16 stored words read back unchanged.
- R4: One read cycle after a read select strobe is accepted, the output register shows the new queue's head word with rd_valid high, without any read request.
- R5: While rd_req_n is high, rd_valid and rd_data hold their values.
- R6: While rd_req_n is low and rd_valid is high, one word is consumed per read cycle and the next word follows on the next cycle. A request while rd_valid is low is ignored and consumes nothing.
- R7: The almost-empty flag rd_ae_n is low while the selected read queue's unread count, including the word on rd_data, is at most ae_level. It rises after a write takes that count above ae_level. The rise happens no earlier than two read edges and no later than five read edges after the write.
- R8: rd_ae_n returns low once reads bring the count back to ae_level or below.
- R9: After reset, rd_valid and rd_ae_n are low and both sides have queue 0 selected.
- R10: Words written to one queue never appear when a different queue is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| wr_sel_stb | input | 1 | Write queue select strobe |
| wr_sel_addr | input | 8 | Write selection: identity [7:5], queue [4:0] |
| wr_en | input | 1 | Write enable, active high |
| wr_data | input | 18 | Write data |
| rd_sel_stb | input | 1 | Read queue select strobe |
| rd_sel_addr | input | 8 | Read selection: identity [7:5], queue [4:0] |
| rd_req_n | input | 1 | Read request, active low |
| ae_level | input | 4 | Almost-empty threshold shared by all queues |
| rd_data | output | 18 | Registered head word of the read queue |
| rd_valid | output | 1 | rd_data holds a word |
| rd_ae_n | output | 1 | Low when the read queue is almost empty |

## Verification
Pointer corruption is the main internal fault to watch for. A read pointer that drifts shows up at the next pop as a repeated or skipped word on rd_data. A write pointer that drifts shows up as a wrong word count once a queue is drained. A queue selection latched one cycle early or late sends the words written around the strobe into the wrong queue. This becomes visible as soon as the two queues are read back. A synchronizer fault shows up as rd_ae_n rising outside its window of a few read cycles.

// File: rtl/mqueue_pkg.sv
package mqueue_pkg;
  localparam int unsigned NQ_DEF    = 32;
  localparam int unsigned DEPTH_DEF = 16;
  localparam int unsigned DW_DEF    = 18;
  localparam int unsigned SELW_DEF  = 8;
  localparam logic [2:0]  ID_DEF    = 3'd5;
endpackage

// File: rtl/mqueue_gray_sync.sv
module mqueue_gray_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      dout <= '0;
    end else begin
      meta <= din;
      dout <= meta;
    end
  end
endmodule

// File: rtl/mqueue_wr_side.sv
module mqueue_wr_side #(
  parameter int unsigned NQ     = 32,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned SELW   = 8,
  parameter int unsigned DEV_ID = 5,
  localparam int unsigned QW    = $clog2(NQ),
  localparam int unsigned PW    = $clog2(DEPTH) + 1,
  localparam int unsigned IDW   = SELW - QW
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sel_stb,
  input  logic [SELW-1:0]        sel_addr,
  input  logic                   wr_en,
  input  logic [NQ-1:0][PW-1:0]  rgray_sync,
  output logic [NQ-1:0][PW-1:0]  wgray,
  output logic                   mem_we,
  output logic [QW+PW-2:0]       mem_addr,
  output logic [QW-1:0]          cur_q,
  output logic                   pend_v,
  output logic [QW-1:0]          pend_q,
  output logic [PW-1:0]          cur_wptr,
  output logic [PW-1:0]          cur_rptr
);
  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [NQ-1:0][PW-1:0] wptr;
  logic                  full;
  logic [PW-1:0]         nxt;
  logic                  id_ok;

  assign id_ok    = (sel_addr[SELW-1:QW] == IDW'(DEV_ID));
  assign cur_wptr = wptr[cur_q];
  assign cur_rptr = g2b(rgray_sync[cur_q]);
  assign full     = (cur_wptr[PW-1] != cur_rptr[PW-1]) &&
                    (cur_wptr[PW-2:0] == cur_rptr[PW-2:0]);
  assign mem_we   = wr_en && !full;
  assign mem_addr = {cur_q, cur_wptr[PW-2:0]};
  assign nxt      = cur_wptr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      pend_v <= 1'b0;
      pend_q <= '0;
      wptr   <= '0;
      wgray  <= '0;
    end else begin
      pend_v <= sel_stb && id_ok;
      if (sel_stb && id_ok) pend_q <= sel_addr[QW-1:0];
      if (pend_v) cur_q <= pend_q;
      if (mem_we) begin
        wptr[cur_q]  <= nxt;
        wgray[cur_q] <= nxt ^ (nxt >> 1);
      end
    end
  end
endmodule

// File: rtl/mqueue_rd_side.sv
module mqueue_rd_side #(
  parameter int unsigned NQ     = 32,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DW     = 18,
  parameter int unsigned SELW   = 8,
  parameter int unsigned DEV_ID = 5,
  localparam int unsigned QW    = $clog2(NQ),
  localparam int unsigned PW    = $clog2(DEPTH) + 1,
  localparam int unsigned IDW   = SELW - QW
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sel_stb,
  input  logic [SELW-1:0]        sel_addr,
  input  logic                   rd_req_n,
  input  logic [PW-2:0]          ae_level,
  input  logic [NQ-1:0][PW-1:0]  wgray_sync,
  input  logic [DW-1:0]          mem_rdata,
  output logic [NQ-1:0][PW-1:0]  rgray,
  output logic [QW+PW-2:0]       mem_raddr,
  output logic [DW-1:0]          rd_data,
  output logic                   rd_valid,
  output logic                   rd_ae_n,
  output logic                   pend_v,
  output logic [PW-1:0]          cur_rptr
);
  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [NQ-1:0][PW-1:0] rptr;
  logic [QW-1:0]         cur_q, pend_q, nq;
  logic                  pop, id_ok;
  logic [PW-1:0]         nptr, wbin_n, wbin_c, occ, popped;

  assign id_ok    = (sel_addr[SELW-1:QW] == IDW'(DEV_ID));
  assign pop      = rd_valid && !rd_req_n;
  assign cur_rptr = rptr[cur_q];
  assign popped   = cur_rptr + 1'b1;
  assign nq       = pend_v ? pend_q : cur_q;
  assign nptr     = (pop && nq == cur_q) ? popped : rptr[nq];
  assign wbin_n   = g2b(wgray_sync[nq]);
  assign wbin_c   = g2b(wgray_sync[cur_q]);
  assign occ      = wbin_c - cur_rptr;
  assign mem_raddr = {nq, nptr[PW-2:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q    <= '0;
      pend_v   <= 1'b0;
      pend_q   <= '0;
      rptr     <= '0;
      rgray    <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      rd_ae_n  <= 1'b0;
    end else begin
      pend_v <= sel_stb && id_ok;
      if (sel_stb && id_ok) pend_q <= sel_addr[QW-1:0];
      if (pend_v) cur_q <= pend_q;
      if (pop) begin
        rptr[cur_q]  <= popped;
        rgray[cur_q] <= popped ^ (popped >> 1);
      end
      rd_data  <= mem_rdata;
      rd_valid <= (nptr != wbin_n);
      rd_ae_n  <= (occ > {1'b0, ae_level});
    end
  end
endmodule

// File: rtl/mqueue_fifo.sv
module mqueue_fifo #(
  parameter int unsigned NQ     = mqueue_pkg::NQ_DEF,
  parameter int unsigned DEPTH  = mqueue_pkg::DEPTH_DEF,
  parameter int unsigned DW     = mqueue_pkg::DW_DEF,
  parameter int unsigned SELW   = mqueue_pkg::SELW_DEF,
  parameter int unsigned DEV_ID = mqueue_pkg::ID_DEF,
  localparam int unsigned QW    = $clog2(NQ),
  localparam int unsigned PW    = $clog2(DEPTH) + 1,
  localparam int unsigned AW    = QW + PW - 1
) (
  input  logic            wclk,
  input  logic            rclk,
  input  logic            rst,
  input  logic            wr_sel_stb,
  input  logic [SELW-1:0] wr_sel_addr,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  input  logic            rd_sel_stb,
  input  logic [SELW-1:0] rd_sel_addr,
  input  logic            rd_req_n,
  input  logic [PW-2:0]   ae_level,
  output logic [DW-1:0]   rd_data,
  output logic            rd_valid,
  output logic            rd_ae_n
);
  logic [NQ-1:0][PW-1:0] wgray, wgray_s, rgray, rgray_s;
  logic                  mem_we;
  logic [AW-1:0]         waddr, raddr;
  logic [DW-1:0]         mem_rdata;
  logic [DW-1:0]         mem [NQ*DEPTH];
  logic [QW-1:0]         w_cur_q, w_pend_q;
  logic                  w_pend_v, r_pend_v;
  logic [PW-1:0]         w_cur_wptr, w_cur_rptr, r_cur_rptr;

  mqueue_gray_sync #(.W(NQ*PW)) u_w2r (
    .clk(rclk), .rst(rst), .din(wgray), .dout(wgray_s));
  mqueue_gray_sync #(.W(NQ*PW)) u_r2w (
    .clk(wclk), .rst(rst), .din(rgray), .dout(rgray_s));

  mqueue_wr_side #(.NQ(NQ), .DEPTH(DEPTH), .SELW(SELW), .DEV_ID(DEV_ID)) u_wr (
    .clk(wclk), .rst(rst), .sel_stb(wr_sel_stb), .sel_addr(wr_sel_addr),
    .wr_en(wr_en), .rgray_sync(rgray_s), .wgray(wgray), .mem_we(mem_we),
    .mem_addr(waddr), .cur_q(w_cur_q), .pend_v(w_pend_v), .pend_q(w_pend_q),
    .cur_wptr(w_cur_wptr), .cur_rptr(w_cur_rptr));

  mqueue_rd_side #(.NQ(NQ), .DEPTH(DEPTH), .DW(DW), .SELW(SELW), .DEV_ID(DEV_ID)) u_rd (
    .clk(rclk), .rst(rst), .sel_stb(rd_sel_stb), .sel_addr(rd_sel_addr),
    .rd_req_n(rd_req_n), .ae_level(ae_level), .wgray_sync(wgray_s),
    .mem_rdata(mem_rdata), .rgray(rgray), .mem_raddr(raddr),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ae_n(rd_ae_n),
    .pend_v(r_pend_v), .cur_rptr(r_cur_rptr));

  always_ff @(posedge wclk) begin
    if (mem_we) mem[waddr] <= wr_data;
  end
  assign mem_rdata = mem[raddr];
endmodule

// File: rtl/mqueue_fifo_chk.sv
module mqueue_fifo_chk #(
  parameter int unsigned QW     = 5,
  parameter int unsigned PW     = 5,
  parameter int unsigned DW     = 18,
  parameter int unsigned SELW   = 8,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DEV_ID = 5
) (
  input logic            wclk,
  input logic            rclk,
  input logic            rst,
  input logic            wr_sel_stb,
  input logic [SELW-1:0] wr_sel_addr,
  input logic            w_pend_v,
  input logic [QW-1:0]   w_pend_q,
  input logic [QW-1:0]   w_cur_q,
  input logic [PW-1:0]   w_cur_wptr,
  input logic [PW-1:0]   w_cur_rptr,
  input logic            r_pend_v,
  input logic [PW-1:0]   r_cur_rptr,
  input logic            rd_valid,
  input logic            rd_req_n,
  input logic [DW-1:0]   rd_data
);
  logic [PW-1:0] w_occ;
  assign w_occ = w_cur_wptr - w_cur_rptr;

  a_r1_foreign_id_ignored: assert property (@(posedge wclk) disable iff (rst)
    (wr_sel_stb && wr_sel_addr[SELW-1:QW] != (SELW-QW)'(DEV_ID)) |=> !w_pend_v);

  a_r2_switch_latency: assert property (@(posedge wclk) disable iff (rst)
    w_pend_v |=> (w_cur_q == $past(w_pend_q)));

  a_r3_no_overflow: assert property (@(posedge wclk) disable iff (rst)
    w_occ <= PW'(DEPTH));

  a_r5_hold: assert property (@(posedge rclk) disable iff (rst)
    (rd_valid && rd_req_n && !r_pend_v) |=> (rd_valid && $stable(rd_data)));

  a_r6_no_underflow: assert property (@(posedge rclk) disable iff (rst)
    (!rd_valid && !r_pend_v) |=> $stable(r_cur_rptr));
endmodule

bind mqueue_fifo mqueue_fifo_chk #(.QW(QW), .PW(PW), .DW(DW), .SELW(SELW),
  .DEPTH(DEPTH), .DEV_ID(DEV_ID)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst(rst), .wr_sel_stb(wr_sel_stb),
  .wr_sel_addr(wr_sel_addr), .w_pend_v(w_pend_v), .w_pend_q(w_pend_q),
  .w_cur_q(w_cur_q), .w_cur_wptr(w_cur_wptr), .w_cur_rptr(w_cur_rptr),
  .r_pend_v(r_pend_v), .r_cur_rptr(r_cur_rptr), .rd_valid(rd_valid),
  .rd_req_n(rd_req_n), .rd_data(rd_data));

// File: tb/sim_mqueue_fifo.sv
`timescale 1ns/1ps
module sim_mqueue_fifo;
  logic        wclk = 1'b0, rclk = 1'b0, rst = 1'b1;
  logic        wr_sel_stb = 1'b0, wr_en = 1'b0, rd_sel_stb = 1'b0, rd_req_n = 1'b1;
  logic [7:0]  wr_sel_addr = '0, rd_sel_addr = '0;
  logic [17:0] wr_data = '0;
  logic [3:0]  ae_level = 4'd2;
  logic [17:0] rd_data;
  logic        rd_valid, rd_ae_n;
  int checks = 0, errors = 0;

  always #10 wclk = ~wclk;
  initial begin #3; forever #10 rclk = ~rclk; end

  mqueue_fifo u0 (.wclk(wclk), .rclk(rclk), .rst(rst), .wr_sel_stb(wr_sel_stb),
    .wr_sel_addr(wr_sel_addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_sel_stb(rd_sel_stb), .rd_sel_addr(rd_sel_addr), .rd_req_n(rd_req_n),
    .ae_level(ae_level), .rd_data(rd_data), .rd_valid(rd_valid), .rd_ae_n(rd_ae_n));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wsel(input logic [2:0] id, input logic [4:0] q);
    @(negedge wclk); wr_sel_stb = 1'b1; wr_sel_addr = {id, q};
    @(negedge wclk); wr_sel_stb = 1'b0;
    @(negedge wclk);
  endtask

  task automatic wword(input logic [17:0] d);
    @(negedge wclk); wr_en = 1'b1; wr_data = d;
    @(negedge wclk); wr_en = 1'b0;
  endtask

  task automatic rsel(input logic [2:0] id, input logic [4:0] q);
    @(negedge rclk); rd_sel_stb = 1'b1; rd_sel_addr = {id, q};
    @(negedge rclk); rd_sel_stb = 1'b0;
    @(negedge rclk);
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
  endtask

  task automatic pop_expect(input string req, input logic [17:0] d);
    check(req, {31'd0, rd_valid}, 32'd1);
    check(req, {14'd0, rd_data}, {14'd0, d});
    rd_req_n = 1'b0;
    @(negedge rclk); rd_req_n = 1'b1;
  endtask

  task automatic t_reset();
    check("R9 valid", {31'd0, rd_valid}, 32'd0);
    check("R9 ae_n", {31'd0, rd_ae_n}, 32'd0);
    wword(18'h00ABC);
    settle();
    pop_expect("R9 queue0", 18'h00ABC);
    check("R6 empty after", {31'd0, rd_valid}, 32'd0);
  endtask

  task automatic t_basic();
    wsel(3'd5, 5'd3);
    for (int i = 0; i < 3; i++) wword(18'h100 + 18'(i));
    rsel(3'd5, 5'd3);
    settle();
    check("R4 fwft valid", {31'd0, rd_valid}, 32'd1);
    check("R4 fwft data", {14'd0, rd_data}, 32'h100);
    for (int i = 0; i < 3; i++) begin
      @(negedge rclk);
      check("R5 hold", {14'd0, rd_data}, 32'h100);
    end
    pop_expect("R6 pop0", 18'h100);
    pop_expect("R6 pop1", 18'h101);
    pop_expect("R6 pop2", 18'h102);
    check("R6 drained", {31'd0, rd_valid}, 32'd0);
    rd_req_n = 1'b0; @(negedge rclk); rd_req_n = 1'b1;
    wword(18'h103);
    settle();
    pop_expect("R6 empty pop ignored", 18'h103);
  endtask

  task automatic t_switch();
    @(negedge wclk); wr_sel_stb = 1'b1; wr_sel_addr = {3'd5, 5'd6};
    wr_en = 1'b1; wr_data = 18'h201;
    @(negedge wclk); wr_sel_stb = 1'b0; wr_data = 18'h202;
    @(negedge wclk); wr_data = 18'h301;
    @(negedge wclk); wr_data = 18'h302;
    @(negedge wclk); wr_en = 1'b0;
    settle();
    pop_expect("R2 old queue w0", 18'h201);
    pop_expect("R2 old queue w1", 18'h202);
    check("R2 old queue end", {31'd0, rd_valid}, 32'd0);
    rsel(3'd5, 5'd6);
    pop_expect("R2 new queue w0", 18'h301);
    pop_expect("R2 new queue w1", 18'h302);
  endtask

  task automatic t_id();
    wsel(3'd2, 5'd7);
    wword(18'h3AA);
    rsel(3'd5, 5'd7);
    settle();
    check("R1 foreign id write", {31'd0, rd_valid}, 32'd0);
    rsel(3'd2, 5'd6);
    settle();
    check("R1 foreign id read", {31'd0, rd_valid}, 32'd0);
    rsel(3'd5, 5'd6);
    pop_expect("R1 stayed in queue6", 18'h3AA);
  endtask

  task automatic t_full();
    wsel(3'd5, 5'd9);
    for (int i = 0; i < 18; i++) wword(18'h400 + 18'(i));
    rsel(3'd5, 5'd9);
    settle();
    for (int i = 0; i < 16; i++) pop_expect("R3 stored", 18'h400 + 18'(i));
    check("R3 extra dropped", {31'd0, rd_valid}, 32'd0);
  endtask

  task automatic t_iso();
    wsel(3'd5, 5'd12);
    wword(18'h500);
    rsel(3'd5, 5'd13);
    settle();
    check("R10 other queue empty", {31'd0, rd_valid}, 32'd0);
    rsel(3'd5, 5'd12);
    pop_expect("R10 own queue", 18'h500);
  endtask

  task automatic t_flag();
    ae_level = 4'd2;
    wsel(3'd5, 5'd11);
    rsel(3'd5, 5'd11);
    settle();
    check("R7 empty low", {31'd0, rd_ae_n}, 32'd0);
    wword(18'h600); wword(18'h601);
    settle();
    check("R7 at level low", {31'd0, rd_ae_n}, 32'd0);
    wword(18'h602);
    @(negedge rclk);
    check("R7 not too early", {31'd0, rd_ae_n}, 32'd0);
    repeat (5) @(negedge rclk);
    check("R7 rose", {31'd0, rd_ae_n}, 32'd1);
    pop_expect("R8 pop", 18'h600);
    @(negedge rclk);
    check("R8 fell", {31'd0, rd_ae_n}, 32'd0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge wclk);
    rst = 1'b0;
    @(negedge rclk);
    t_reset();
    t_basic();
    t_switch();
    t_id();
    t_full();
    t_iso();
    t_flag();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule